// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Word FIFO

This block receives asynchronous serial frames on a single input line and hands completed words to a host over a parallel read port. Each frame starts with a start bit, carries 8 or 9 data bits with the least significant bit first, and ends with one stop bit. A separate shift register assembles each frame. When a frame is complete, the word moves into a two-entry FIFO. The host sees the oldest word at the FIFO head and pops it with a one-cycle read strobe.

The bit rate is set by a divisor and a prescale. The divisor is 8 or 16 bits wide and produces a sample tick. The prescale sets how many sample ticks make up one bit: 64, 16 or 4. The input line can be inverted before data recovery.

A nine-bit mode stores a ninth bit with each word. Framing errors are flagged per word. An overrun is flagged when a third word completes while both FIFO entries are still unread. A data-available flag, gated by an interrupt enable, drives the interrupt output.

Top module: `serial_rx_fifo`

## Requirements
- R1: A frame is a start bit (low), 8 data bits LSB first, then a stop bit (high). Once the word reaches the FIFO head, its byte appears on data_o.
- R2: With nine_bit_i=1, a ninth data bit follows bit 7 and is presented on bit9_o with its word. With nine_bit_i=0, bit9_o reads 0.
- R3: Completed words enter a 2-entry FIFO. data_o, bit9_o and frame_err_o show the oldest unread word. A one-cycle rd_i pulse while data is available pops that word.
- R4: If a word completes while both FIFO entries are unread and no pop happens in that cycle, overrun_o goes to 1 and the word is dropped. The two stored words stay readable in order.
- R5: While overrun_o is 1, no completed word enters the FIFO. overrun_o clears only when rx_en_i is driven to 0.
- R6: frame_err_o is 1 for a word whose stop bit was sampled low, and 0 otherwise. It follows the FIFO head.
- R7: avail_o is 1 exactly while the FIFO holds unread data. irq_o equals avail_o AND irq_en_i.
- R8: Reception proceeds only while both port_en_i and rx_en_i are 1. Frames sent otherwise leave avail_o at 0.
- R9: With invert_i=1, the line is inverted before recovery, so the idle level is low and the start bit is high.
- R10: One bit lasts (D+1)*P clock cycles. D is div_i when wide_div_i=1, or div_i[7:0] when wide_div_i=0. P is 64, 16 or 4 for presc_sel_i = 0, 1, or 2/3.
- R11: A start pulse that returns high before the middle of the start bit is rejected, and no word is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Serial port enable |
| rx_en_i | input | 1 | Continuous receive enable; 0 clears overrun |
| nine_bit_i | input | 1 | 1 = 9 data bits per frame |
| invert_i | input | 1 | 1 = invert the RX line |
| wide_div_i | input | 1 | 1 = 16-bit divisor, 0 = low 8 bits only |
| presc_sel_i | input | 2 | Ticks per bit: 0 = 64, 1 = 16, 2/3 = 4 |
| div_i | input | 16 | Baud divisor |
| irq_en_i | input | 1 | Interrupt enable |
| rd_i | input | 1 | Pop the FIFO head |
| rx_i | input | 1 | Serial input line |
| data_o | output | 8 | Head word data |
| bit9_o | output | 1 | Head word ninth bit |
| frame_err_o | output | 1 | Head word framing error |
| overrun_o | output | 1 | Overrun error, sticky |
| avail_o | output | 1 | FIFO holds unread data |
| irq_o | output | 1 | Data-available interrupt |

## Verification
Most internal faults show up at the ports within one frame time. A mis-aligned bit counter or tick count shifts data_o or corrupts the stop sample, so frame_err_o reads wrong on the very next word. A broken FIFO pointer or occupancy count shows up within one or two reads: words come out in the wrong order, repeat, or avail_o stays high after the last pop. A faulty overrun path appears on the third unread frame or on the first frame after recovery, as either a missing overrun_o or a word that should not have been stored.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       bit9;
    logic       ferr;
  } srx_word_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } srx_state_e;
endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             wide_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int HALF_W = DIV_W / 2;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;

  assign limit  = wide_i ? div_i : {{(DIV_W-HALF_W){1'b0}}, div_i[HALF_W-1:0]};
  assign tick_o = !restart_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (restart_i || cnt_q >= limit) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  // R10: with a nonzero divisor, ticks never land on back-to-back cycles
  p_tick_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && limit != '0) |=> (!tick_o || limit == '0));
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       line_i,
  input  logic       tick_i,
  input  logic       nine_bit_i,
  input  logic [1:0] presc_sel_i,
  output logic       restart_o,
  output logic       valid_o,
  output srx_word_t  word_o
);
  srx_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tpb;
  logic [CNT_W-1:0] half;
  logic [3:0]       bitn_q;
  logic [3:0]       last_bit;
  logic [8:0]       sh_q;
  logic             prev_q;
  logic             fall;

  always_comb begin
    case (presc_sel_i)
      2'd0:    tpb = CNT_W'(64);
      2'd1:    tpb = CNT_W'(16);
      default: tpb = CNT_W'(4);
    endcase
  end
  assign half      = tpb >> 1;
  assign last_bit  = nine_bit_i ? 4'd8 : 4'd7;
  assign fall      = prev_q && !line_i;
  assign restart_o = !run_i || (state_q == ST_IDLE && fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      prev_q  <= 1'b1;
      valid_o <= 1'b0;
      word_o  <= '0;
    end else begin
      prev_q  <= line_i;
      valid_o <= 1'b0;
      if (!run_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        bitn_q  <= '0;
      end else begin
        case (state_q)
          ST_IDLE: if (fall) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
          ST_START: if (tick_i) begin
            if (cnt_q == half - 1'b1) begin
              cnt_q   <= '0;
              bitn_q  <= '0;
              // confirm the start at mid-bit
              state_q <= line_i ? ST_IDLE : ST_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: if (tick_i) begin
            if (cnt_q == tpb - 1'b1) begin
              cnt_q <= '0;
              sh_q  <= {line_i, sh_q[8:1]};
              if (bitn_q == last_bit) state_q <= ST_STOP;
              else                    bitn_q  <= bitn_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: if (tick_i) begin
            if (cnt_q == tpb - 1'b1) begin
              cnt_q       <= '0;
              state_q     <= ST_IDLE;
              valid_o     <= 1'b1;
              word_o.data <= nine_bit_i ? sh_q[7:0] : sh_q[8:1];
              word_o.bit9 <= nine_bit_i & sh_q[8];
              word_o.ferr <= !line_i;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_idle_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (state_q == ST_IDLE && !valid_o));
  p_single_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  srx_word_t wdata_i,
  input  logic      pop_i,
  input  logic      ovr_clr_i,
  output srx_word_t head_o,
  output logic      avail_o,
  output logic      overrun_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  srx_word_t        mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] count_q;
  logic             full, do_pop, do_push, ovr_hit;

  assign full    = (count_q == CNT_W'(DEPTH));
  assign do_pop  = pop_i && (count_q != '0);
  assign ovr_hit = push_i && !overrun_o && full && !do_pop;
  assign do_push = push_i && !overrun_o && !ovr_hit;
  assign avail_o = (count_q != '0);
  assign head_o  = avail_o ? mem_q[rd_q] : '0;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             mem_q[g] <= '0;
        else if (do_push && wr_q == PTR_W'(g))   mem_q[g] <= wdata_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= '0;
      rd_q      <= '0;
      count_q   <= '0;
      overrun_o <= 1'b0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: ;
      endcase
      if (ovr_clr_i)    overrun_o <= 1'b0;
      else if (ovr_hit) overrun_o <= 1'b1;
    end
  end

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_ovr_on_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && !ovr_clr_i) |=> overrun_o);
  p_ovr_blocks_push_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !pop_i) |=> (count_q == $past(count_q)));
  p_ovr_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !ovr_clr_i) |=> overrun_o);
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import srx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DEPTH  = 2,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             port_en_i,
  input  logic             rx_en_i,
  input  logic             nine_bit_i,
  input  logic             invert_i,
  input  logic             wide_div_i,
  input  logic [1:0]       presc_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             irq_en_i,
  input  logic             rd_i,
  input  logic             rx_i,
  output logic [7:0]       data_o,
  output logic             bit9_o,
  output logic             frame_err_o,
  output logic             overrun_o,
  output logic             avail_o,
  output logic             irq_o
);
  logic [SYNC_N-1:0] sync_q;
  logic      line, run, tick, restart, wvalid;
  srx_word_t word, head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_N-2:0], rx_i};
  end

  assign line = sync_q[SYNC_N-1] ^ invert_i;
  assign run  = port_en_i && rx_en_i;

  srx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni, .restart_i(restart), .wide_i(wide_div_i),
    .div_i, .tick_o(tick)
  );

  srx_frame u_frame (
    .clk_i, .rst_ni, .run_i(run), .line_i(line), .tick_i(tick),
    .nine_bit_i, .presc_sel_i, .restart_o(restart),
    .valid_o(wvalid), .word_o(word)
  );

  srx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(wvalid), .wdata_i(word), .pop_i(rd_i),
    .ovr_clr_i(!rx_en_i), .head_o(head), .avail_o, .overrun_o
  );

  assign data_o      = head.data;
  assign bit9_o      = head.bit9;
  assign frame_err_o = head.ferr;
  assign irq_o       = avail_o && irq_en_i;

  p_irq_needs_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avail_o |-> !irq_o);
endmodule

// File: tb/serial_rx_fifo_tb.sv
`timescale 1ns/1ps
module serial_rx_fifo_tb;
  logic clk = 0, rst_n = 0;
  logic port_en = 1, rx_en = 1, nine = 0, inv = 0, wide = 0, irq_en = 0, rd = 0, rx = 1;
  logic [1:0]  presc = 2'd1;
  logic [15:0] div = 16'd1;
  logic [7:0]  data;
  logic bit9, ferr, ovr, avail, irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  serial_rx_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .rx_en_i(rx_en),
    .nine_bit_i(nine), .invert_i(inv), .wide_div_i(wide), .presc_sel_i(presc),
    .div_i(div), .irq_en_i(irq_en), .rd_i(rd), .rx_i(rx),
    .data_o(data), .bit9_o(bit9), .frame_err_o(ferr), .overrun_o(ovr),
    .avail_o(avail), .irq_o(irq)
  );

  function automatic int bit_period(input logic w, input logic [15:0] d, input logic [1:0] p);
    int dd = w ? int'(d) : int'(d[7:0]);
    int pp = (p == 2'd0) ? 64 : (p == 2'd1) ? 16 : 4;
    return (dd + 1) * pp;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input int cyc);
    rx = v ^ inv;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input logic stop_v);
    int per = bit_period(wide, div, presc);
    drive_bit(1'b0, per);
    for (int i = 0; i < (nine ? 9 : 8); i++) drive_bit(d[i], per);
    drive_bit(stop_v, per);
    drive_bit(1'b1, per);
  endtask

  task automatic pop();
    rd = 1; @(negedge clk); rd = 0; @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R7 reset avail", avail, 0);
    chk("R4 reset ovr", ovr, 0);
    chk("R7 reset irq", irq, 0);

    // R1 basic byte, 16 ticks/bit
    send(9'h0A5, 1'b1);
    chk("R1 data", data, 8'hA5);
    chk("R6 no ferr", ferr, 0);
    chk("R2 bit9 zero in 8-bit", bit9, 0);
    chk("R7 avail", avail, 1);
    chk("R7 irq gated off", irq, 0);
    irq_en = 1; @(negedge clk);
    chk("R7 irq on", irq, 1);
    pop();
    chk("R3 empty after pop", avail, 0);
    chk("R7 irq drops", irq, 0);

    // R2 nine-bit
    nine = 1;
    send(9'h13C, 1'b1);
    chk("R2 data", data, 8'h3C);
    chk("R2 bit9", bit9, 1);
    pop();
    nine = 0;

    // R6 framing error follows head; R3 order
    send(9'h011, 1'b0);
    send(9'h022, 1'b1);
    chk("R6 ferr head0", ferr, 1);
    chk("R3 head0", data, 8'h11);
    pop();
    chk("R6 ferr head1", ferr, 0);
    chk("R3 head1", data, 8'h22);
    pop();

    // R4/R5 overrun
    send(9'h0C1, 1'b1); send(9'h0C2, 1'b1); send(9'h0C3, 1'b1);
    chk("R4 ovr set", ovr, 1);
    chk("R4 keep first", data, 8'hC1);
    pop();
    chk("R4 keep second", data, 8'hC2);
    pop();
    chk("R4 third dropped", avail, 0);
    send(9'h0C4, 1'b1);
    chk("R5 blocked while ovr", avail, 0);
    chk("R5 ovr sticky", ovr, 1);
    rx_en = 0; @(negedge clk); @(negedge clk);
    chk("R5 ovr cleared", ovr, 0);
    // R8 disabled receive
    send(9'h0D1, 1'b1);
    chk("R8 rx_en off ignored", avail, 0);
    rx_en = 1; port_en = 0;
    send(9'h0D2, 1'b1);
    chk("R8 port off ignored", avail, 0);
    port_en = 1;
    send(9'h0D3, 1'b1);
    chk("R5 accepts after clear", data, 8'hD3);
    pop();

    // R9 inversion
    inv = 1; drive_bit(1'b1, 40);
    send(9'h05A, 1'b1);
    chk("R9 inverted data", data, 8'h5A);
    pop();
    inv = 0; drive_bit(1'b1, 40);

    // R10 divisor width: narrow ignores high byte, wide uses it
    presc = 2'd2; wide = 0; div = 16'h0107;
    send(9'h0E7, 1'b1);
    chk("R10 narrow div", data, 8'hE7);
    pop();
    wide = 1; div = 16'h0101;
    send(9'h07E, 1'b1);
    chk("R10 wide div", data, 8'h7E);
    pop();
    presc = 2'd0; wide = 0; div = 16'd0;
    send(9'h099, 1'b1);
    chk("R10 presc 64", data, 8'h99);
    pop();

    // R11 glitch rejected
    presc = 2'd1; div = 16'd3;
    rx = 0; repeat (bit_period(wide, div, presc) / 4) @(negedge clk);
    rx = 1; repeat (12 * bit_period(wide, div, presc)) @(negedge clk);
    chk("R11 glitch no word", avail, 0);

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic [8:0] d = 9'($urandom);
      logic fe = ($urandom % 5) == 0;
      nine  = 1'($urandom);
      presc = 2'($urandom % 3);
      wide  = 1'($urandom);
      div   = (presc == 2'd2) ? 16'(7 + $urandom % 3) : 16'(1 + $urandom % 2);
      drive_bit(1'b1, 8);
      send(d, !fe);
      if (fe) drive_bit(1'b1, bit_period(wide, div, presc));
      chk("R1 rnd data", data, nine ? int'(d[7:0]) : int'(d[7:0]));
      chk("R2 rnd bit9", bit9, nine ? int'(d[8]) : 0);
      chk("R6 rnd ferr", ferr, int'(fe));
      pop();
      chk("R3 rnd empty", avail, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule